// File: doc/BRIEF.md
# Sector-table space vector angle stepper

This block is an open-loop angle generator for a space vector modulator. On each PWM period strobe it moves the output voltage vector forward by one fixed angular step. It presents the current sector number and the two active-vector compare values to a downstream switching sequencer.

The compare values come from a precomputed table. The table covers a single 60-degree sector: N entries, one for each angular position from the sector's leading boundary up to, but not including, the next boundary. That gives N-1 intermediate positions between the two boundary vectors. The step is therefore 60/N degrees. All six sectors reuse the same table.

A direction input sets the order in which the sectors are visited. An enable input freezes the angle and the outputs. One full electrical revolution takes 6*N enabled strobes, which is 360 degrees divided by the step, times the PWM period.

Top module: `svs_angle_stepper`

## Requirements
- R1: While rst_ni is low, sector_o, t1_o and t2_o are all zero. The angle state restarts at sector 0, table position 0.
- R2: sector_o, t1_o and t2_o change only at a clock edge where strobe_i and en_i are both high. At any other edge they hold their value.
- R3: On an enabled strobe the outputs load the current state: sector_o takes the current sector, and t1_o and t2_o take table entry k, where k is the current position. The position then advances by one step.
- R4: Forward rotation (dir_i = 0) increments the position. After position N-1 the position wraps to 0 and the sector increments modulo six, so sector 5 is followed by sector 0.
- R5: Reverse rotation (dir_i = 1) decrements the position. After position 0 the position wraps to N-1 and the sector decrements modulo six, so sector 0 is followed by sector 5.
- R6: While en_i is low, strobes are ignored. The angle state and the outputs hold, and the next enabled strobe resumes from the held angle.
- R7: After 6*N enabled strobes in one direction, the angle returns to its starting state. The output sequence therefore repeats with a period of 6*N strobes.
- R8: sector_o is always in the range 0 to 5.
- R9: Table entry k occupies bits [k*TW +: TW] of t1_tbl_i and of t2_tbl_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables stepping and output updates |
| strobe_i | input | 1 | One-cycle pulse once per PWM period |
| dir_i | input | 1 | Rotation direction: 0 forward, 1 reverse |
| t1_tbl_i | input | N*TW | T1 values for one sector, entry k at [k*TW +: TW] |
| t2_tbl_i | input | N*TW | T2 values for one sector, entry k at [k*TW +: TW] |
| sector_o | output | 3 | Sector of the presented vector, 0 to 5 |
| t1_o | output | TW | T1 compare value for the presented position |
| t2_o | output | TW | T2 compare value for the presented position |

## Verification
The assertions assume the table inputs are static and that strobe_i, en_i and dir_i are sampled cleanly at the clock edge. No state hangs on the width of a strobe, so a strobe held high for several cycles counts as several periods. The stimulus loads the table once before reset is released and never changes it. It drives every control input at the falling edge, and it switches direction only between strobes. A behavioural model of sector and position runs alongside the design and is compared on every clock.

// File: rtl/svs_pkg.sv
package svs_pkg;
  typedef logic [2:0] sector_t;
  localparam sector_t SECTOR_LAST = 3'd5;

  function automatic sector_t sector_inc(sector_t s);
    return (s == SECTOR_LAST) ? 3'd0 : s + 3'd1;
  endfunction

  function automatic sector_t sector_dec(sector_t s);
    return (s == 3'd0) ? SECTOR_LAST : s - 3'd1;
  endfunction
endpackage

// File: rtl/svs_angle_ctr.sv
module svs_angle_ctr
  import svs_pkg::*;
#(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             dir_i,
  output logic [IDX_W-1:0] idx_o,
  output sector_t          sector_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  sector_t          sec_q, sec_d;

  always_comb begin
    idx_d = idx_q;
    sec_d = sec_q;
    if (step_i) begin
      if (!dir_i) begin
        if (idx_q == LAST_IDX) begin
          idx_d = '0;
          sec_d = sector_inc(sec_q);
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else begin
        if (idx_q == '0) begin
          idx_d = LAST_IDX;
          sec_d = sector_dec(sec_q);
        end else begin
          idx_d = idx_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      sec_q <= '0;
    end else begin
      idx_q <= idx_d;
      sec_q <= sec_d;
    end
  end

  assign idx_o    = idx_q;
  assign sector_o = sec_q;

  p_idx_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX);
  p_sector_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q <= SECTOR_LAST);
  p_fwd_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !dir_i && idx_q == LAST_IDX && sec_q == SECTOR_LAST)
      |=> (idx_q == '0 && sec_q == 3'd0));
  p_rev_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && dir_i && idx_q == '0 && sec_q == 3'd0)
      |=> (idx_q == LAST_IDX && sec_q == SECTOR_LAST));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(idx_q) && $stable(sec_q)));
endmodule

// File: rtl/svs_table_rd.sv
module svs_table_rd #(
  parameter int N  = 8,
  parameter int TW = 12,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [N*TW-1:0]  t1_tbl_i,
  input  logic [N*TW-1:0]  t2_tbl_i,
  output logic [TW-1:0]    t1_o,
  output logic [TW-1:0]    t2_o
);
  logic [TW-1:0] t1_arr [N];
  logic [TW-1:0] t2_arr [N];

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign t1_arr[g] = t1_tbl_i[g*TW +: TW];
    assign t2_arr[g] = t2_tbl_i[g*TW +: TW];
  end

  assign t1_o = t1_arr[idx_i];
  assign t2_o = t2_arr[idx_i];
endmodule

// File: rtl/svs_angle_stepper.sv
module svs_angle_stepper
  import svs_pkg::*;
#(
  parameter int N  = 8,
  parameter int TW = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            strobe_i,
  input  logic            dir_i,
  input  logic [N*TW-1:0] t1_tbl_i,
  input  logic [N*TW-1:0] t2_tbl_i,
  output logic [2:0]      sector_o,
  output logic [TW-1:0]   t1_o,
  output logic [TW-1:0]   t2_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic             step;
  logic [IDX_W-1:0] idx;
  sector_t          sec;
  logic [TW-1:0]    t1_rd, t2_rd;
  sector_t          sec_q;
  logic [TW-1:0]    t1_q, t2_q;

  assign step = strobe_i & en_i;

  svs_angle_ctr #(.N(N)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step),
    .dir_i    (dir_i),
    .idx_o    (idx),
    .sector_o (sec)
  );

  svs_table_rd #(.N(N), .TW(TW)) u_tbl (
    .idx_i    (idx),
    .t1_tbl_i (t1_tbl_i),
    .t2_tbl_i (t2_tbl_i),
    .t1_o     (t1_rd),
    .t2_o     (t2_rd)
  );

  // present the current angle, counter advances on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      t1_q  <= '0;
      t2_q  <= '0;
    end else if (step) begin
      sec_q <= sec;
      t1_q  <= t1_rd;
      t2_q  <= t2_rd;
    end
  end

  assign sector_o = sec_q;
  assign t1_o     = t1_q;
  assign t2_o     = t2_q;

  p_out_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_i && en_i) |=> ($stable(sector_o) && $stable(t1_o) && $stable(t2_o)));
  p_out_sector_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && en_i) |=> (sector_o == $past(sec)));
  p_out_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sector_o <= 3'd5);
endmodule

// File: tb/svs_angle_stepper_tb_top.sv
module svs_angle_stepper_tb_top;
  localparam int N  = 8;
  localparam int TW = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0, strobe = 1'b0, dir = 1'b0;
  logic [N*TW-1:0] t1_tbl, t2_tbl;
  logic [2:0]      sector_o;
  logic [TW-1:0]   t1_o, t2_o;

  int t1v [N];
  int t2v [N];
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  string tag = "R3";

  // model state
  int m_sec = 0, m_idx = 0;
  int e_sec = 0, e_t1 = 0, e_t2 = 0;

  always #2 clk = ~clk;

  svs_angle_stepper #(.N(N), .TW(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .strobe_i(strobe), .dir_i(dir),
    .t1_tbl_i(t1_tbl), .t2_tbl_i(t2_tbl),
    .sector_o(sector_o), .t1_o(t1_o), .t2_o(t2_o)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sec <= 0; m_idx <= 0; e_sec <= 0; e_t1 <= 0; e_t2 <= 0;
    end else if (strobe && en) begin
      e_sec <= m_sec;
      e_t1  <= t1v[m_idx];
      e_t2  <= t2v[m_idx];
      if (!dir) begin
        if (m_idx == N - 1) begin m_idx <= 0; m_sec <= (m_sec + 1) % 6; end
        else m_idx <= m_idx + 1;
      end else begin
        if (m_idx == 0) begin m_idx <= N - 1; m_sec <= (m_sec + 5) % 6; end
        else m_idx <= m_idx - 1;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk({tag, " sector"}, int'(sector_o), e_sec);
      chk({tag, " t1"}, int'(t1_o), e_t1);
      chk({tag, " t2"}, int'(t2_o), e_t2);
      chk("R8 range", int'(sector_o <= 3'd5), 1);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual %0d expected below 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic pulses(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) strobe = 1'b1;
      @(negedge clk) strobe = 1'b0;
      for (int j = 0; j < gap; j++) @(negedge clk);
    end
  endtask

  initial begin
    int s0, a0, b0;
    for (int k = 0; k < N; k++) begin
      t1v[k] = 100 + 37 * k;
      t2v[k] = 900 - 53 * k;
      t1_tbl[k*TW +: TW] = TW'(t1v[k]);
      t2_tbl[k*TW +: TW] = TW'(t2v[k]);
    end
    repeat (3) @(negedge clk);
    chk("R1 sector", int'(sector_o), 0);
    chk("R1 t1", int'(t1_o), 0);
    chk("R1 t2", int'(t2_o), 0);
    rst_ni = 1'b1;
    en = 1'b1;
    // R3 first strobe presents entry 0 of sector 0 (R9 field position)
    tag = "R3";
    pulses(1, 2);
    chk("R3 first t1", int'(t1_o), t1v[0]);
    chk("R9 first t2", int'(t2_o), t2v[0]);
    s0 = sector_o; a0 = t1_o; b0 = t2_o;
    // R2 no strobe, idle cycles: outputs hold
    tag = "R2";
    repeat (5) @(negedge clk);
    chk("R2 hold t1", int'(t1_o), a0);
    // R4 forward through all wraps, then R7 full revolution
    tag = "R4";
    pulses(6 * N - 1, 1);
    tag = "R7";
    pulses(1, 1);
    chk("R7 sector repeat", int'(sector_o), s0);
    chk("R7 t1 repeat", int'(t1_o), a0);
    chk("R7 t2 repeat", int'(t2_o), b0);
    // back-to-back strobes
    tag = "R4";
    @(negedge clk) strobe = 1'b1;
    repeat (N + 3) @(negedge clk);
    strobe = 1'b0;
    // R6 enable low: strobes ignored
    tag = "R6";
    en = 1'b0;
    a0 = t1_o; s0 = sector_o;
    pulses(5, 0);
    chk("R6 hold t1", int'(t1_o), a0);
    chk("R6 hold sector", int'(sector_o), s0);
    en = 1'b1;
    pulses(1, 1);
    // R5 reverse across 0 -> 5 wrap several times
    tag = "R5";
    dir = 1'b1;
    pulses(6 * N + 5, 0);
    tag = "R7";
    pulses(6 * N, 0);
    // mixed directions
    tag = "R5";
    for (int r = 0; r < 10; r++) begin
      dir = r[0];
      pulses(r + 3, r % 3);
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule